// File: doc/BRIEF.md
# Checksum-Gated Shadow Coefficient Bank

This block is a memory-mapped register window for changing coefficient sets while the rest of the chip keeps running. Software writes new coefficient words one at a time into a shadow bank. It picks the destination bank and latches that choice with a shadow-load write. It then writes the CRC32 it expects over the staged words and issues a commit. The commit copies the whole shadow bank into the chosen active bank in a single cycle, but only when the CRC computed in hardware matches and no error is pending.

Errors never touch the active banks. Each kind of error sets its own sticky status bit, which stays set until software clears it. The errors are partial byte strobes, coefficient values outside the allowed range, a bad bank choice, a read-only destination, and a failed checksum. The bus side is a plain single-clock write/read strobe port with byte enables, and it has no bus-protocol logic of its own. A simplified AXI4-Lite front end or a pre-decoded MMIO strobe source can drive it directly. All active banks are exported flat for the datapath that consumes the coefficients.

Top module: `coef_commit_window`

## Requirements
- R1: After reset the following hold. Status (0x0C), select (0x04) and expected CRC (0x08) read 0. Banks 0 and 1 are zero and marked not valid. Bank 2 is read-only, valid, and holds word k equal to k.
- R2: A write with all four strobes set to 0x100+4k (k < 8) stores word k of the shadow bank. A read returns data on rd_data in the cycle after rd_en, and reading 0x100+4k returns shadow word k.
- R3: Any write whose wr_strb is not 4'b1111 is not applied and sets sticky status bit 0 (partial write).
- R4: A shadow write whose signed value is above COEF_MAX (default 32767) sets status bit 4. One below COEF_MIN (default -32768) sets status bit 5. In both cases the shadow word keeps its old value. The boundary values themselves are accepted.
- R5: A write to 0x10 (shadow load) latches select bits [1:0] as the commit target and sets status bit 6 (loaded). A target of 3 or more sets status bit 2 instead. A read-only target sets status bit 3 instead. In both failing cases the loaded bit is left clear.
- R6: Writes to the select register after a shadow load do not change the bank that the pending commit writes.
- R7: The CRC is the reflected CRC32 with polynomial 0xEDB88320, initial value 0xFFFFFFFF and final inversion. It runs over shadow words 0 to 7 in ascending order, with each word fed least significant bit first (bytes in little-endian order).
- R8: A control write (0x00) with bit 0 set and bit 1 clear commits only when three conditions hold: loaded is set, status bits 5:0 are zero, and the CRC matches 0x08. A commit copies all shadow words into the target bank, marks the bank valid, adds one to the commit count in status bits 15:8 (modulo 256), and clears loaded.
- R9: A commit whose CRC does not match sets status bit 1. It leaves the active banks and the count unchanged and keeps loaded set, so a corrected CRC can be retried.
- R10: A commit with loaded clear sets status bit 2. A commit while any of status bits 5:0 is set is refused with no change to any state.
- R11: A control write with bit 1 set clears status bits 5:0 and leaves loaded and the count as they were. A commit bit in the same write is ignored.
- R12: A read of 0x200+4k returns word k of the bank named by select bits [5:4]. If that bank is 3 or more, or has never been committed, the read returns 0 and sets status bit 2.
- R13: active_q holds bank b word k at bits [(b*8+k)*32 +: 32], and it changes only on a successful commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 12 | Write byte address |
| wr_data | input | 32 | Write data |
| wr_strb | input | 4 | Byte enables of the write |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 12 | Read byte address |
| rd_data | output | 32 | Registered read data, valid the cycle after rd_en |
| active_q | output | 768 | All active banks, flattened |

## Verification
The bench commits a run of coefficient sets to two banks, some with a correct CRC and some with a corrupted one. A design that got the CRC bit order or the final inversion wrong would refuse every good commit. A design that ignored the checksum would overwrite a bank on the bad entries. The bench also retargets the select register between shadow load and commit, which catches a design that samples the selection at commit time. It commits while a range trap is pending, which catches a design that gates only on the CRC. It writes clear and commit together, writes values one step beyond each range boundary, and reads a bank that was never committed. Each of these shows at the ports as a wrong status word, an unexpected active_q value, or a nonzero readback.

// File: rtl/cw_pkg.sv
package cw_pkg;
  localparam int DW    = 32;
  localparam int AW    = 12;
  localparam int SW    = DW / 8;
  localparam int SEL_W = 2;
  localparam int CNT_W = 8;
  localparam int NFLAG = 6;

  localparam logic [AW-1:0] A_CTRL   = 12'h000;
  localparam logic [AW-1:0] A_SEL    = 12'h004;
  localparam logic [AW-1:0] A_XCRC   = 12'h008;
  localparam logic [AW-1:0] A_STAT   = 12'h00C;
  localparam logic [AW-1:0] A_LOAD   = 12'h010;
  localparam logic [AW-1:0] A_SHADOW = 12'h100;
  localparam logic [AW-1:0] A_ACTIVE = 12'h200;

  localparam int F_PARTIAL = 0;
  localparam int F_CRC     = 1;
  localparam int F_INVSEL  = 2;
  localparam int F_RDONLY  = 3;
  localparam int F_OVF     = 4;
  localparam int F_UNF     = 5;

  localparam int VIEW_LO = 4;

  // one 32-bit step of the reflected CRC, data bits taken LSB first
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [31:0] w);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 32; i++)
      r = (r >> 1) ^ (((r[0] ^ w[i]) != 1'b0) ? 32'hEDB88320 : 32'h0);
    return r;
  endfunction
endpackage

// File: rtl/cw_crc32.sv
module cw_crc32 import cw_pkg::*; #(
  parameter int N_WORDS = 8
) (
  input  logic [N_WORDS*DW-1:0] words,
  output logic [31:0]           crc
);
  logic [31:0] acc;

  // linear in the data: folds into XOR trees of logarithmic depth
  always_comb begin
    acc = 32'hFFFF_FFFF;
    for (int k = 0; k < N_WORDS; k++)
      acc = crc_step(acc, words[k*DW +: DW]);
    crc = ~acc;
  end
endmodule

// File: rtl/cw_shadow.sv
module cw_shadow import cw_pkg::*; #(
  parameter int N_WORDS  = 8,
  parameter int COEF_MIN = -32768,
  parameter int COEF_MAX = 32767,
  parameter int IDX_W    = $clog2(N_WORDS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr,
  input  logic [IDX_W-1:0]      idx,
  input  logic [DW-1:0]         data,
  output logic [N_WORDS*DW-1:0] words,
  output logic                  ovf_hit,
  output logic                  unf_hit
);
  logic [DW-1:0] mem [N_WORDS];

  assign ovf_hit = wr && ($signed(data) > COEF_MAX);
  assign unf_hit = wr && ($signed(data) < COEF_MIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N_WORDS; k++) mem[k] <= '0;
    end else if (wr && !ovf_hit && !unf_hit) begin
      mem[idx] <= data;
    end
  end

  for (genvar k = 0; k < N_WORDS; k++) begin : g_out
    assign words[k*DW +: DW] = mem[k];
  end
endmodule

// File: rtl/cw_banks.sv
module cw_banks import cw_pkg::*; #(
  parameter int                 N_BANKS = 3,
  parameter int                 N_WORDS = 8,
  parameter logic [N_BANKS-1:0] RO_MASK = 3'b100
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          commit,
  input  logic [SEL_W-1:0]              tgt,
  input  logic [N_WORDS*DW-1:0]         shadow,
  output logic [N_BANKS*N_WORDS*DW-1:0] active,
  output logic [N_BANKS-1:0]            valid
);
  localparam int BANK_BITS = N_WORDS * DW;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    if (RO_MASK[b]) begin : g_ro
      for (genvar k = 0; k < N_WORDS; k++) begin : g_word
        assign active[(b*N_WORDS+k)*DW +: DW] = DW'(k);
      end
      assign valid[b] = 1'b1;
    end else begin : g_rw
      logic [BANK_BITS-1:0] store;
      logic                 v;
      always_ff @(posedge clk) begin
        if (rst) begin
          store <= '0;
          v     <= 1'b0;
        end else if (commit && (tgt == SEL_W'(b))) begin
          store <= shadow;
          v     <= 1'b1;
        end
      end
      assign active[b*BANK_BITS +: BANK_BITS] = store;
      assign valid[b] = v;
    end
  end
endmodule

// File: rtl/coef_commit_window.sv
module coef_commit_window import cw_pkg::*; #(
  parameter int                 N_BANKS  = 3,
  parameter int                 N_WORDS  = 8,
  parameter logic [N_BANKS-1:0] RO_MASK  = 3'b100,
  parameter int                 COEF_MIN = -32768,
  parameter int                 COEF_MAX = 32767
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [AW-1:0]                 wr_addr,
  input  logic [DW-1:0]                 wr_data,
  input  logic [SW-1:0]                 wr_strb,
  input  logic                          rd_en,
  input  logic [AW-1:0]                 rd_addr,
  output logic [DW-1:0]                 rd_data,
  output logic [N_BANKS*N_WORDS*DW-1:0] active_q
);
  localparam int              IDX_W  = $clog2(N_WORDS);
  localparam int              NSEL   = 1 << SEL_W;
  localparam logic [AW-1:0]   SH_END = AW'(A_SHADOW + N_WORDS*4);
  localparam logic [AW-1:0]   AC_END = AW'(A_ACTIVE + N_WORDS*4);

  logic [DW-1:0]         sel_q, xcrc_q;
  logic [NFLAG-1:0]      flags_q, flag_set;
  logic                  loaded_q;
  logic [SEL_W-1:0]      tgt_q;
  logic [CNT_W-1:0]      count_q;
  logic [N_WORDS*DW-1:0] sh_words;
  logic [31:0]           crc_calc;
  logic [N_BANKS-1:0]    bank_valid;
  logic [NSEL-1:0]       valid_pad, ro_pad;

  // write-side decode
  logic             wr_full, in_sh_w, ovf_hit, unf_hit;
  logic [IDX_W-1:0] w_idx;
  assign wr_full = wr_en && (wr_strb == '1);
  assign in_sh_w = wr_full && (wr_addr >= A_SHADOW) && (wr_addr < SH_END) && (wr_addr[1:0] == 2'b00);
  assign w_idx   = IDX_W'((wr_addr - A_SHADOW) >> 2);

  logic             load_wr, load_bad, load_ro, load_ok;
  logic [SEL_W-1:0] sel_tgt;
  assign sel_tgt  = sel_q[SEL_W-1:0];
  assign ro_pad   = NSEL'(RO_MASK);
  assign load_wr  = wr_full && (wr_addr == A_LOAD);
  assign load_bad = load_wr && (int'(sel_tgt) >= N_BANKS);
  assign load_ro  = load_wr && !load_bad && ro_pad[sel_tgt];
  assign load_ok  = load_wr && !load_bad && !load_ro;

  logic ctrl_wr, do_clear, commit_req, crc_ok, commit_go;
  assign ctrl_wr    = wr_full && (wr_addr == A_CTRL);
  assign do_clear   = ctrl_wr && wr_data[1];
  assign commit_req = ctrl_wr && wr_data[0] && !wr_data[1];
  assign crc_ok     = (crc_calc == xcrc_q);
  assign commit_go  = commit_req && loaded_q && (flags_q == '0) && crc_ok;

  // read-side decode
  logic             in_sh_r, in_ac_r, view_ok, rd_bad_view;
  logic [IDX_W-1:0] r_idx;
  logic [SEL_W-1:0] view;
  assign in_sh_r     = (rd_addr >= A_SHADOW) && (rd_addr < SH_END) && (rd_addr[1:0] == 2'b00);
  assign in_ac_r     = (rd_addr >= A_ACTIVE) && (rd_addr < AC_END) && (rd_addr[1:0] == 2'b00);
  assign r_idx       = IDX_W'((rd_addr - (in_ac_r ? A_ACTIVE : A_SHADOW)) >> 2);
  assign view        = sel_q[VIEW_LO +: SEL_W];
  assign valid_pad   = NSEL'(bank_valid);
  assign view_ok     = valid_pad[view];
  assign rd_bad_view = rd_en && in_ac_r && !view_ok;

  cw_shadow #(.N_WORDS(N_WORDS), .COEF_MIN(COEF_MIN), .COEF_MAX(COEF_MAX)) u_shadow (
    .clk(clk), .rst(rst), .wr(in_sh_w), .idx(w_idx), .data(wr_data),
    .words(sh_words), .ovf_hit(ovf_hit), .unf_hit(unf_hit));

  cw_crc32 #(.N_WORDS(N_WORDS)) u_crc (.words(sh_words), .crc(crc_calc));

  cw_banks #(.N_BANKS(N_BANKS), .N_WORDS(N_WORDS), .RO_MASK(RO_MASK)) u_banks (
    .clk(clk), .rst(rst), .commit(commit_go), .tgt(tgt_q), .shadow(sh_words),
    .active(active_q), .valid(bank_valid));

  always_comb begin
    flag_set            = '0;
    flag_set[F_PARTIAL] = wr_en && (wr_strb != '1);
    flag_set[F_OVF]     = ovf_hit;
    flag_set[F_UNF]     = unf_hit;
    flag_set[F_INVSEL]  = load_bad || (commit_req && !loaded_q) || rd_bad_view;
    flag_set[F_RDONLY]  = load_ro;
    flag_set[F_CRC]     = commit_req && loaded_q && (flags_q == '0) && !crc_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= '0;
      xcrc_q   <= '0;
      flags_q  <= '0;
      loaded_q <= 1'b0;
      tgt_q    <= '0;
      count_q  <= '0;
    end else begin
      if (wr_full && (wr_addr == A_SEL))  sel_q  <= wr_data;
      if (wr_full && (wr_addr == A_XCRC)) xcrc_q <= wr_data;
      if (load_ok) begin
        tgt_q    <= sel_tgt;
        loaded_q <= 1'b1;
      end
      if (commit_go) begin
        loaded_q <= 1'b0;
        count_q  <= count_q + 1'b1;
      end
      flags_q <= do_clear ? '0 : (flags_q | flag_set);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= '0;
      if (rd_addr == A_SEL)       rd_data <= sel_q;
      else if (rd_addr == A_XCRC) rd_data <= xcrc_q;
      else if (rd_addr == A_STAT) rd_data <= {16'h0, count_q, 1'b0, loaded_q, flags_q};
      else if (in_sh_r)           rd_data <= sh_words[r_idx*DW +: DW];
      else if (in_ac_r && view_ok)
        rd_data <= active_q[(int'(view)*N_WORDS + int'(r_idx))*DW +: DW];
    end
  end
endmodule

// File: rtl/cw_window_chk.sv
module cw_window_chk import cw_pkg::*; #(
  parameter int N_WORDS  = 8,
  parameter int ACT_W    = 768,
  parameter int COEF_MIN = -32768,
  parameter int COEF_MAX = 32767
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [DW-1:0]    wr_data,
  input logic [SW-1:0]    wr_strb,
  input logic [ACT_W-1:0] active_q,
  input logic [NFLAG-1:0] flags,
  input logic [CNT_W-1:0] count
);
  localparam logic [AW-1:0] SH_END = AW'(A_SHADOW + N_WORDS*4);

  logic coef_wr, clear_wr;
  assign coef_wr  = wr_en && (wr_strb == '1) && (wr_addr >= A_SHADOW) && (wr_addr < SH_END)
                    && (wr_addr[1:0] == 2'b00);
  assign clear_wr = wr_en && (wr_strb == '1) && (wr_addr == A_CTRL) && wr_data[1];

  // R3
  partial_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_strb != '1)) |=> flags[F_PARTIAL])
    else $error("partial strobe did not raise its flag");

  // R4
  over_range_chk: assert property (@(posedge clk) disable iff (rst)
    (coef_wr && ($signed(wr_data) > COEF_MAX)) |=> flags[F_OVF])
    else $error("over-range value did not trap");

  // R4
  under_range_chk: assert property (@(posedge clk) disable iff (rst)
    (coef_wr && ($signed(wr_data) < COEF_MIN)) |=> flags[F_UNF])
    else $error("under-range value did not trap");

  // R13
  active_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (wr_addr == A_CTRL)) |=> $stable(active_q))
    else $error("active banks moved without a control write");

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (count != $past(count)) |-> (count == $past(count) + 1'b1))
    else $error("commit count moved by other than one");

  // R8
  active_counted_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(active_q) |-> (count == $past(count) + 1'b1))
    else $error("active change without counted commit");

  // R11
  flag_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(flags) & ~flags) != '0) |-> $past(clear_wr))
    else $error("sticky flag dropped without a clear");
endmodule

bind coef_commit_window cw_window_chk #(
  .N_WORDS(N_WORDS), .ACT_W(N_BANKS*N_WORDS*cw_pkg::DW),
  .COEF_MIN(COEF_MIN), .COEF_MAX(COEF_MAX)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .wr_strb(wr_strb), .active_q(active_q), .flags(flags_q), .count(count_q)
);

// File: tb/tb_coef_commit_window.sv
`timescale 1ns/1ps
module tb_coef_commit_window;
  localparam int NB = 3;
  localparam int NW = 8;
  localparam int ACT_W = NB*NW*32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0]      wr_addr = '0, rd_addr = '0;
  logic [31:0]      wr_data = '0;
  logic [3:0]       wr_strb = '0;
  logic [31:0]      rd_data;
  logic [ACT_W-1:0] act;

  always #2 clk = ~clk;

  coef_commit_window dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_strb(wr_strb), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .active_q(act));

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] mshadow [NW];
  logic [31:0] mact [NB][NW];
  int mcount = 0;

  // {bank[3:0], good_crc[3:0], seed[7:0]}
  localparam logic [15:0] VEC [6] = '{16'h0101, 16'h1102, 16'h0003, 16'h0103, 16'h1004, 16'h1105};

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chk_port(input string tag);
    logic [ACT_W-1:0] e;
    for (int b = 0; b < NB; b++)
      for (int k = 0; k < NW; k++) e[(b*NW+k)*32 +: 32] = mact[b][k];
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: active_q got %h expected %h", tag, act, e);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s = 4'hF);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_strb = s;
    @(negedge clk);
    wr_en = 1'b0; wr_strb = 4'h0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  function automatic logic [31:0] stat(input logic [5:0] f, input logic ld);
    return {16'h0, 8'(mcount), 1'b0, ld, f};
  endfunction

  function automatic logic [31:0] coefval(input int seed, input int k);
    int v;
    v = ((seed * 7919 + k * 4099) % 65535) - 32767;
    return 32'(v);
  endfunction

  // bytewise reflected CRC32, bytes of each word little-endian
  function automatic logic [31:0] crc_ref();
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < NW; k++)
      for (int by = 0; by < 4; by++) begin
        c = c ^ {24'h0, mshadow[k][by*8 +: 8]};
        for (int i = 0; i < 8; i++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      end
    return ~c;
  endfunction

  task automatic stage(input int seed);
    for (int k = 0; k < NW; k++) begin
      mshadow[k] = coefval(seed, k);
      wr(12'h100 + 12'(4*k), mshadow[k]);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    for (int b = 0; b < NB; b++)
      for (int k = 0; k < NW; k++) mact[b][k] = (b == 2) ? 32'(k) : 32'h0;
    for (int k = 0; k < NW; k++) mshadow[k] = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(12'h00C, d); chk("R1 status", d, 32'h0);
    rd(12'h004, d); chk("R1 select", d, 32'h0);
    rd(12'h008, d); chk("R1 xcrc", d, 32'h0);
    chk_port("R1 active_q");
    rd(12'h200, d); chk("R1 bank0 invalid", d, 32'h0);
    rd(12'h00C, d); chk("R1/R12 invalid view flag", d, stat(6'h04, 1'b0));
    wr(12'h004, 32'h20);
    rd(12'h214, d); chk("R1 read-only word5", d, 32'd5);
    wr(12'h000, 32'h2);

    // table-driven commits
    foreach (VEC[i]) begin
      int bank, seed;
      bit good;
      bank = int'(VEC[i][15:12]); good = VEC[i][8]; seed = int'(VEC[i][7:0]);
      stage(seed);
      rd(12'h11C, d); chk("R2 shadow readback", d, mshadow[NW-1]);
      wr(12'h004, 32'(bank | (bank << 4)));
      wr(12'h010, 32'h0);
      wr(12'h008, good ? crc_ref() : (crc_ref() ^ 32'h1));
      wr(12'h000, 32'h1);
      if (good) begin
        for (int k = 0; k < NW; k++) mact[bank][k] = mshadow[k];
        mcount++;
        rd(12'h00C, d); chk("R8/R7 commit status", d, stat(6'h0, 1'b0));
      end else begin
        rd(12'h00C, d); chk("R9 mismatch status", d, stat(6'h02, 1'b1));
        wr(12'h000, 32'h2);
        rd(12'h00C, d); chk("R11 clear keeps loaded", d, stat(6'h0, 1'b1));
      end
      chk_port("R13 active_q after commit");
      for (int k = 0; k < NW; k++) begin
        rd(12'h200 + 12'(4*k), d); chk("R12 active readback", d, mact[bank][k]);
      end
    end

    // R3 partial strobe
    wr(12'h100, 32'h55, 4'h7);
    rd(12'h100, d); chk("R3 partial not applied", d, mshadow[0]);
    rd(12'h00C, d); chk("R3 partial flag", d, stat(6'h01, 1'b0));
    wr(12'h000, 32'h2);

    // R4 range traps and boundaries
    wr(12'h104, 32'd32767); mshadow[1] = 32'd32767;
    wr(12'h104, 32'd32768);
    rd(12'h104, d); chk("R4 overflow rejected", d, 32'd32767);
    wr(12'h108, 32'hFFFF_7FFF);
    wr(12'h108, 32'hFFFF_8000); mshadow[2] = 32'hFFFF_8000;
    rd(12'h108, d); chk("R4 min boundary accepted", d, 32'hFFFF_8000);
    rd(12'h00C, d); chk("R4 trap flags", d, stat(6'h30, 1'b0));

    // R10 commit refused while flags pending
    wr(12'h004, 32'h0);
    wr(12'h010, 32'h0);
    wr(12'h008, crc_ref());
    wr(12'h000, 32'h1);
    rd(12'h00C, d); chk("R10 refused with flags", d, stat(6'h30, 1'b1));
    chk_port("R10 active unchanged");
    // R11 clear with commit bit ignores the commit
    wr(12'h000, 32'h3);
    rd(12'h00C, d); chk("R11 clear+commit", d, stat(6'h0, 1'b1));
    chk_port("R11 no commit on clear");
    wr(12'h000, 32'h1);
    for (int k = 0; k < NW; k++) mact[0][k] = mshadow[k];
    mcount++;
    chk_port("R8 commit after clear");
    rd(12'h00C, d); chk("R8 count", d, stat(6'h0, 1'b0));

    // R5 bad targets
    wr(12'h004, 32'h3);
    wr(12'h010, 32'h0);
    rd(12'h00C, d); chk("R5 nonexistent bank", d, stat(6'h04, 1'b0));
    wr(12'h000, 32'h2);
    wr(12'h004, 32'h2);
    wr(12'h010, 32'h0);
    rd(12'h00C, d); chk("R5 read-only bank", d, stat(6'h08, 1'b0));
    wr(12'h000, 32'h2);

    // R6 retarget after shadow load
    stage(9);
    wr(12'h004, 32'h1);
    wr(12'h010, 32'h0);
    wr(12'h004, 32'h0);
    wr(12'h008, crc_ref());
    wr(12'h000, 32'h1);
    for (int k = 0; k < NW; k++) mact[1][k] = mshadow[k];
    mcount++;
    chk_port("R6 commit keeps latched bank");

    // R10 commit without load
    wr(12'h000, 32'h1);
    rd(12'h00C, d); chk("R10 commit without load", d, stat(6'h04, 1'b0));
    chk_port("R10 active unchanged no load");
    wr(12'h000, 32'h2);

    // R12 nonexistent view
    wr(12'h004, 32'h30);
    rd(12'h204, d); chk("R12 bad view data", d, 32'h0);
    rd(12'h00C, d); chk("R12 bad view flag", d, stat(6'h04, 1'b0));

    finish_run();
  end
endmodule